// File: doc/BRIEF.md
# Host and DMA Front End with Parity-Carrying Data Queue

This block is the host-facing edge of a small-computer-bus controller. It links a processor register port and an 8-bit DMA port to a 16-entry data queue. Each entry of the queue holds a byte and its parity bit. The bus sequencer behind the block reads the queue's occupancy count and flags. The sequencer also supplies the current transfer direction, so the DMA port never chooses it.

A strap input selects one of two bus arrangements. With the strap low, register cycles and DMA cycles share one 8-bit data bus. With the strap high, register cycles move to a separate 8-bit bus, so a processor access and a DMA transfer can complete in the same clock. Every bus the block can drive comes with an output-enable.

All ports are sampled on the rising clock edge. A register strobe or a DMA acknowledge that is held high for one clock counts as one access. Read data appears combinationally during the clock in which the read is active.

Top module: `hdf_front`

## Requirements
- R1: While the synchronous reset `rst` is high, `db_oe` and `pad_oe` stay low. After reset the queue is empty (`fifo_count` 0, `fifo_empty` 1, `fifo_full` 0), `dreq` is 0, and every register reads 0.
- R2: With `mode_split`=0, a register read drives `db_out` and raises `db_oe`, and a register write takes its data from `db_in`. `pad_oe` never rises in this mode.
- R3: With `mode_split`=1, register reads drive `pad_out` with `pad_oe` and register writes take `pad_in`. A DMA transfer in the same clock still completes.
- R4: When `dir_read`=0, every clock with `dack`=1 and `dbwr`=1 pushes `{db_in_par, db_in}` into the queue. A `dbwr` pulse without `dack` pushes nothing.
- R5: When `dir_read`=1, every clock with `dack`=1 drives the oldest queue entry onto `db_out`/`db_out_par`, raises `db_oe`, and pops that entry. `db_oe` is low whenever `dack` is low, except during a strap-low register read.
- R6: The parity bit passes through the queue unchanged on the DMA path. A byte written by the processor is stored with odd parity, meaning the parity bit is the inverted XOR of the byte. Register reads on `db_out` carry odd parity in the same way.
- R7: The queue is first-in first-out and holds 16 entries. A push into a full queue is dropped. A pop from an empty queue leaves the count at 0.
- R8: Address 0 is the queue data port. Addresses 1 to 7 are 8-bit read/write registers. Addresses 8 to 15 read as 0 and ignore writes. A cycle in which both `rd` and `wr` are high is not an access.
- R9: After each clock edge outside reset, `dreq` is 1 exactly when the queue is not full (if `dir_read` was 0 at that edge) or not empty (if `dir_read` was 1).
- R10: With `mode_split`=0, a register read or write in a clock with `dack`=1 is ignored. It neither writes a register, pops the queue nor drives `db_out`.
- R11: In either mode, a processor access to address 0 in a clock with `dack`=1 is ignored.
- R12: `fifo_count` equals the number of stored entries, `fifo_empty` is 1 exactly when that number is 0, and `fifo_full` is 1 exactly when it is 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_split | input | 1 | Strap: 0 shared data bus, 1 separate register bus |
| dir_read | input | 1 | Transfer direction from the running command: 1 queue to DMA, 0 DMA to queue |
| cs | input | 1 | Register chip select |
| rd | input | 1 | Register read strobe |
| wr | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| pad_in | input | 8 | Register bus data in (split mode) |
| pad_out | output | 8 | Register bus data out (split mode) |
| pad_oe | output | 1 | Register bus output enable |
| db_in | input | 8 | Shared/DMA bus data in |
| db_in_par | input | 1 | Shared/DMA bus parity in |
| db_out | output | 8 | Shared/DMA bus data out |
| db_out_par | output | 1 | Shared/DMA bus parity out |
| db_oe | output | 1 | Shared/DMA bus output enable |
| dack | input | 1 | DMA acknowledge |
| dbwr | input | 1 | DMA write strobe |
| dreq | output | 1 | DMA request |
| fifo_empty | output | 1 | Queue empty flag |
| fifo_full | output | 1 | Queue full flag |
| fifo_count | output | 5 | Queue occupancy |

## Verification
A wrong read or write pointer does not change the count. It shows up as a byte or parity mismatch on `db_out` during the first DMA drain that follows, so every byte pushed is compared on its way out. A wrong occupancy count or flag shows up at `fifo_count`, `fifo_full` or `dreq` one edge after the push or pop that caused it, and the bench compares these after every clock. A steering fault shows up in the same clock as an output enable that is raised when it should be low, or the reverse, most visibly on the shared bus in the clocks where a register strobe and `dack` coincide.

// File: rtl/hdf_pkg.sv
package hdf_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              par;
        logic [BYTE_W-1:0] data;
    } fentry_t;

    // odd parity: the nine bits together hold an odd number of ones
    function automatic logic odd_par(input logic [BYTE_W-1:0] d);
        return ~^d;
    endfunction

endpackage

// File: rtl/hdf_fifo.sv
module hdf_fifo
    import hdf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  fentry_t       wr_ent,
    output fentry_t       head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          empty_nx,
    output logic          full_nx
);

    typedef struct packed {
        fentry_t [DEPTH-1:0] mem;
        logic    [PW-1:0]    rp;
        logic    [PW-1:0]    wp;
        logic    [CW-1:0]    cnt;
        logic                emp;
        logic                ful;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop & ~st_q.emp;
        do_push = push & (~st_q.ful | do_pop);
        if (do_push) begin
            st_d.mem[st_q.wp] = wr_ent;
            st_d.wp           = st_q.wp + 1'b1;
        end
        if (do_pop) begin
            st_d.rp = st_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        st_d.emp = (st_d.cnt == '0);
        st_d.ful = (st_d.cnt == CW'(DEPTH));
        if (rst) begin
            st_d     = '0;
            st_d.emp = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign head     = st_q.mem[st_q.rp];
    assign count    = st_q.cnt;
    assign empty    = st_q.emp;
    assign full     = st_q.ful;
    assign empty_nx = st_d.emp;
    assign full_nx  = st_d.ful;

endmodule

// File: rtl/hdf_regfile.sv
module hdf_regfile
    import hdf_pkg::*;
#(
    parameter int NREG = 8,
    parameter int AW   = 4,
    localparam int IW  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);

    typedef struct packed {
        logic [NREG-1:0][BYTE_W-1:0] regs;
    } rf_st_t;

    rf_st_t rf_d, rf_q;
    logic          in_range;
    logic [IW-1:0] idx;

    assign in_range = (addr != '0) && (32'(addr) < NREG);
    assign idx      = addr[IW-1:0];

    always_comb begin
        rf_d = rf_q;
        for (int i = 1; i < NREG; i++) begin
            if (we && in_range && (idx == IW'(i))) begin
                rf_d.regs[i] = wdata;
            end
        end
        if (rst) begin
            rf_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        rf_q <= rf_d;
    end

    assign rdata = in_range ? rf_q.regs[idx] : '0;

endmodule

// File: rtl/hdf_steer.sv
module hdf_steer
    import hdf_pkg::*;
#(
    parameter int AW        = 4,
    parameter int FIFO_ADDR = 0
) (
    input  logic              rst,
    input  logic              mode_split,
    input  logic              dir_read,
    input  logic              dack,
    input  logic              dbwr,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] db_in,
    input  logic              db_in_par,
    input  logic [BYTE_W-1:0] pad_in,
    input  fentry_t           fifo_head,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              fifo_push,
    output logic              fifo_pop,
    output fentry_t           fifo_wr_ent,
    output logic              reg_we,
    output logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] db_out,
    output logic              db_out_par,
    output logic              db_oe,
    output logic [BYTE_W-1:0] pad_out,
    output logic              pad_oe
);

    logic fifo_sel, blocked, acc_rd, acc_wr, dma_push, dma_pop;
    logic [BYTE_W-1:0] host_rdata;

    always_comb begin
        fifo_sel = (addr == AW'(FIFO_ADDR));
        // shared bus: any DMA cycle wins; split bus: only the queue port collides
        blocked  = dack & (~mode_split | fifo_sel);
        acc_rd   = ~rst & cs & rd & ~wr & ~blocked;
        acc_wr   = ~rst & cs & wr & ~rd & ~blocked;
        dma_push = ~rst & dack & ~dir_read & dbwr;
        dma_pop  = ~rst & dack & dir_read;

        host_wdata = mode_split ? pad_in : db_in;
        host_rdata = fifo_sel ? fifo_head.data : reg_rdata;

        fifo_push = dma_push | (acc_wr & fifo_sel);
        fifo_pop  = dma_pop | (acc_rd & fifo_sel);
        if (dma_push) begin
            fifo_wr_ent.data = db_in;
            fifo_wr_ent.par  = db_in_par;
        end else begin
            fifo_wr_ent.data = host_wdata;
            fifo_wr_ent.par  = odd_par(host_wdata);
        end
        reg_we = acc_wr & ~fifo_sel;

        db_oe      = dma_pop | (acc_rd & ~mode_split);
        db_out     = '0;
        db_out_par = 1'b0;
        if (dma_pop) begin
            db_out     = fifo_head.data;
            db_out_par = fifo_head.par;
        end else if (db_oe) begin
            db_out     = host_rdata;
            db_out_par = odd_par(host_rdata);
        end

        pad_oe  = acc_rd & mode_split;
        pad_out = pad_oe ? host_rdata : '0;
    end

endmodule

// File: rtl/hdf_front.sv
module hdf_front
    import hdf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NREG  = 8,
    parameter int AW    = 4,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_split,
    input  logic              dir_read,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [AW-1:0]     addr,
    input  logic [BYTE_W-1:0] pad_in,
    output logic [BYTE_W-1:0] pad_out,
    output logic              pad_oe,
    input  logic [BYTE_W-1:0] db_in,
    input  logic              db_in_par,
    output logic [BYTE_W-1:0] db_out,
    output logic              db_out_par,
    output logic              db_oe,
    input  logic              dack,
    input  logic              dbwr,
    output logic              dreq,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic [CW-1:0]     fifo_count
);

    fentry_t           head, wr_ent;
    logic              push, pop, reg_we, empty_nx, full_nx;
    logic [BYTE_W-1:0] reg_rdata, host_wdata;

    typedef struct packed {
        logic dreq;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    hdf_steer #(.AW(AW), .FIFO_ADDR(0)) u_steer (
        .rst        (rst),
        .mode_split (mode_split),
        .dir_read   (dir_read),
        .dack       (dack),
        .dbwr       (dbwr),
        .cs         (cs),
        .rd         (rd),
        .wr         (wr),
        .addr       (addr),
        .db_in      (db_in),
        .db_in_par  (db_in_par),
        .pad_in     (pad_in),
        .fifo_head  (head),
        .reg_rdata  (reg_rdata),
        .fifo_push  (push),
        .fifo_pop   (pop),
        .fifo_wr_ent(wr_ent),
        .reg_we     (reg_we),
        .host_wdata (host_wdata),
        .db_out     (db_out),
        .db_out_par (db_out_par),
        .db_oe      (db_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    hdf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .pop     (pop),
        .wr_ent  (wr_ent),
        .head    (head),
        .count   (fifo_count),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .empty_nx(empty_nx),
        .full_nx (full_nx)
    );

    hdf_regfile #(.NREG(NREG), .AW(AW)) u_regs (
        .clk  (clk),
        .rst  (rst),
        .we   (reg_we),
        .addr (addr),
        .wdata(host_wdata),
        .rdata(reg_rdata)
    );

    always_comb begin
        ctl_d.dreq = dir_read ? ~empty_nx : ~full_nx;
        if (rst) begin
            ctl_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        ctl_q <= ctl_d;
    end

    assign dreq = ctl_q.dreq;

endmodule

// File: rtl/hdf_front_chk.sv
module hdf_front_chk #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          mode_split,
    input logic          dir_read,
    input logic          dack,
    input logic          cs,
    input logic          rd,
    input logic          pad_oe,
    input logic          db_oe,
    input logic          dreq,
    input logic          fifo_empty,
    input logic          fifo_full,
    input logic [CW-1:0] fifo_count
);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fifo_empty && !fifo_full && fifo_count == '0 && !dreq)); // R1

    AST_PAD_QUIET_SHARED: assert property (@(posedge clk) disable iff (rst)
        !mode_split |-> !pad_oe); // R2

    AST_DB_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (!dack && !(cs && rd && !mode_split)) |-> !db_oe); // R5

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (fifo_count == $past(fifo_count)) ||
        (fifo_count == $past(fifo_count) + 1'b1) ||
        (fifo_count + 1'b1 == $past(fifo_count))); // R7

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        32'(fifo_count) <= DEPTH); // R7

    AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst)
        (fifo_empty == (fifo_count == '0)) &&
        (fifo_full == (32'(fifo_count) == DEPTH))); // R12

    AST_DREQ_TRACK: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (dreq == ($past(dir_read) ? !fifo_empty : !fifo_full))); // R9

endmodule

bind hdf_front hdf_front_chk #(.DEPTH(DEPTH)) u_hdf_front_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_split(mode_split),
    .dir_read  (dir_read),
    .dack      (dack),
    .cs        (cs),
    .rd        (rd),
    .pad_oe    (pad_oe),
    .db_oe     (db_oe),
    .dreq      (dreq),
    .fifo_empty(fifo_empty),
    .fifo_full (fifo_full),
    .fifo_count(fifo_count)
);

// File: tb/test_hdf_front.sv
`timescale 1ns/100ps
module test_hdf_front;

    localparam int DEPTH = 16;
    localparam int NREG  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_split = 1'b0, dir_read = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] pad_in = '0, db_in = '0;
    logic       db_in_par = 1'b0, dack = 1'b0, dbwr = 1'b0;
    logic [7:0] pad_out, db_out;
    logic       pad_oe, db_out_par, db_oe, dreq, fifo_empty, fifo_full;
    logic [4:0] fifo_count;

    int ncmp = 0;
    int nerr = 0;
    logic [8:0] mq[$];
    logic [7:0] mregs[16];

    always #2.5 clk = ~clk;

    hdf_front i_hdf_front (
        .clk(clk), .rst(rst), .mode_split(mode_split), .dir_read(dir_read),
        .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .db_in(db_in), .db_in_par(db_in_par), .db_out(db_out),
        .db_out_par(db_out_par), .db_oe(db_oe),
        .dack(dack), .dbwr(dbwr), .dreq(dreq),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_count(fifo_count)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        ncmp++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_rdata(input logic [3:0] a);
        if (a == 4'd0)       return (mq.size() > 0) ? mq[0][7:0] : 8'h00;
        else if (a < NREG)   return mregs[a];
        else                 return 8'h00;
    endfunction

    function automatic logic exp_dreq(input logic dir);
        return dir ? (mq.size() != 0) : (mq.size() != DEPTH);
    endfunction

    task automatic idle();
        cs = 0; rd = 0; wr = 0; dack = 0; dbwr = 0;
    endtask

    // one clock: inputs already set after a falling edge
    task automatic tick();
        logic hr, hw, fs, blk, ar, aw_, dpush, dpop, hpush, hpop, e_dboe, e_padoe;
        logic popok, pushok, have;
        logic [7:0] wd, rdv;
        logic [8:0] pent;
        #1;
        hr    = cs && rd && !wr;
        hw    = cs && wr && !rd;
        fs    = (addr == 4'd0);
        blk   = dack && (!mode_split || fs);
        ar    = hr && !blk;
        aw_   = hw && !blk;
        dpush = dack && !dir_read && dbwr;
        dpop  = dack && dir_read;
        hpush = aw_ && fs;
        hpop  = ar && fs;
        have  = mq.size() > 0;
        rdv   = exp_rdata(addr);
        wd    = mode_split ? pad_in : db_in;
        e_dboe  = dpop || (ar && !mode_split);
        e_padoe = ar && mode_split;
        chk("R5 R10 db_oe", 32'(db_oe), 32'(e_dboe));
        chk("R2 R3 pad_oe", 32'(pad_oe), 32'(e_padoe));
        if (dpop && have)
            chk("R5 R6 DMA read byte and parity", 32'({db_out_par, db_out}), 32'(mq[0]));
        else if (e_dboe && !dpop && (!fs || have)) begin
            chk("R2 R8 shared-bus register read", 32'(db_out), 32'(rdv));
            chk("R6 register read parity", 32'(db_out_par), 32'(~^rdv));
        end
        if (e_padoe && (!fs || have))
            chk("R3 R8 register-bus read", 32'(pad_out), 32'(rdv));
        popok  = (dpop || hpop) && have;
        pushok = (dpush || hpush) && (mq.size() < DEPTH || popok);
        pent   = dpush ? {db_in_par, db_in} : {~^wd, wd};
        @(posedge clk);
        if (popok)  void'(mq.pop_front());
        if (pushok) mq.push_back(pent);
        if (aw_ && !fs && addr < NREG) mregs[addr] = wd;
        @(negedge clk);
        chk("R12 count", 32'(fifo_count), 32'(mq.size()));
        chk("R12 empty", 32'(fifo_empty), 32'(mq.size() == 0));
        chk("R12 full", 32'(fifo_full), 32'(mq.size() == DEPTH));
        chk("R9 dreq", 32'(dreq), 32'(exp_dreq(dir_read)));
    endtask

    task automatic do_reset();
        rst = 1; cs = 1; rd = 1; wr = 0; dack = 1; dir_read = 1;
        #1;
        chk("R1 db released in reset", 32'(db_oe), 0);
        chk("R1 pad released in reset", 32'(pad_oe), 0);
        repeat (3) @(negedge clk);
        idle(); dir_read = 0; rst = 0;
        mq.delete();
        foreach (mregs[i]) mregs[i] = 8'h00;
        #1;
        chk("R1 count after reset", 32'(fifo_count), 0);
        chk("R1 empty after reset", 32'(fifo_empty), 1);
        chk("R1 full after reset", 32'(fifo_full), 0);
        chk("R1 dreq after reset", 32'(dreq), 0);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [7:0] d);
        idle(); cs = 1; wr = 1; addr = a; db_in = d; pad_in = d;
        tick();
        idle();
    endtask

    task automatic reg_rd(input logic [3:0] a);
        idle(); cs = 1; rd = 1; addr = a;
        tick();
        idle();
    endtask

    initial begin
        #200000;
        ncmp++; nerr++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        for (int a = 1; a < NREG; a++) reg_rd(4'(a));  // R1 registers read zero

        // R2 R8: shared bus register file
        mode_split = 0;
        for (int a = 1; a < 16; a++) reg_wr(4'(a), 8'(8'h30 + a * 7));
        for (int a = 1; a < 16; a++) reg_rd(4'(a));
        idle(); cs = 1; rd = 1; wr = 1; addr = 4'd2; db_in = 8'hEE; tick(); // R8 both strobes
        reg_rd(4'd2);

        // R4 R7 R9: DMA fill past full, varied parity
        dir_read = 0;
        idle(); dbwr = 1; db_in = 8'hAA; tick();                 // R4 strobe without dack
        chk("R4 no push without dack", 32'(fifo_count), 0);
        for (int i = 0; i < DEPTH + 2; i++) begin
            idle(); dack = 1; dbwr = 1; db_in = 8'(i * 13 + 1); db_in_par = i[0];
            tick();
        end
        chk("R7 depth holds sixteen", 32'(fifo_count), 16);
        chk("R9 dreq low when full", 32'(dreq), 0);
        reg_wr(4'd0, 8'h77);                                      // R7 host push into full
        // R10: register write during a DMA cycle on shared bus
        idle(); dack = 1; dbwr = 0; cs = 1; wr = 1; addr = 4'd3; db_in = 8'h5A; tick();
        reg_rd(4'd3);

        // R5 R6: drain through DMA, then pop past empty
        dir_read = 1;
        idle(); tick();
        idle(); dack = 1; cs = 1; rd = 1; addr = 4'd1; tick();   // R10 read ignored
        for (int i = 0; i < DEPTH + 2; i++) begin
            idle(); dack = 1; tick();
        end
        chk("R7 empty pop keeps zero", 32'(fifo_count), 0);
        chk("R9 dreq low when empty", 32'(dreq), 0);

        // R3 R6 R11: split bus
        mode_split = 1; dir_read = 0;
        for (int i = 0; i < 3; i++) reg_wr(4'd0, 8'(8'h81 + i));
        idle(); dack = 1; dbwr = 1; db_in = 8'hC3; db_in_par = 0;
        cs = 1; wr = 1; addr = 4'd5; pad_in = 8'h19; tick();      // R3 concurrent
        reg_rd(4'd5);
        idle(); dack = 1; dbwr = 0; cs = 1; wr = 1; addr = 4'd0; pad_in = 8'h66; tick(); // R11
        chk("R11 queue port ignored under dack", 32'(fifo_count), 4);
        dir_read = 1;
        idle(); tick();
        idle(); dack = 1; cs = 1; rd = 1; addr = 4'd6; tick();   // R3 read with DMA pop
        for (int i = 0; i < 4; i++) begin idle(); dack = 1; tick(); end

        // random phase
        for (int n = 0; n < 6000; n++) begin
            if (n % 1500 == 0) mode_split = $urandom_range(0, 1) != 0;
            if ($urandom_range(0, 19) == 0) dir_read = ~dir_read;
            cs   = $urandom_range(0, 1) != 0;
            rd   = $urandom_range(0, 2) == 0;
            wr   = $urandom_range(0, 2) == 0;
            addr = ($urandom_range(0, 2) == 0) ? 4'd0 : 4'($urandom_range(0, 15));
            dack = $urandom_range(0, 9) < 4;
            dbwr = $urandom_range(0, 3) != 0;
            db_in = 8'($urandom); db_in_par = $urandom_range(0, 1) != 0;
            pad_in = 8'($urandom);
            tick();
        end

        // R1: reset with data stored
        mode_split = 0; dir_read = 0;
        for (int i = 0; i < 5; i++) begin idle(); dack = 1; dbwr = 1; db_in = 8'(i); tick(); end
        do_reset();
        reg_rd(4'd3);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
        $finish;
    end

endmodule